// File: doc/BRIEF.md
# Configurable-order delta-sigma divide-offset modulator

This block converts a constant fractional ratio F/D into a stream of small signed integers, one per comparison cycle. A downstream adder (not part of this block) sums each integer with a nominal integer divide value, so the divider's long-run average becomes the nominal value plus F/D. The block is a cascade of modulo-D accumulators followed by a differencing network. With order k selected, the quantization error reaches the output through a k-th order finite difference, Y = X + (1 - z^-1)^k · E. This pushes the error energy toward high offset frequencies, where the loop filter removes it.

All state advances only on cycles where the comparison-cycle enable is high. The order is chosen by a two-bit code, and any change to that code clears every accumulator and history register. The denominator may be any value from 1 to 2^FRAC_W - 1, and the numerator must be below it.

Top module: `frac_dsm`

## Requirements
- R1: After the asynchronous reset, `offset_o` is 0.
- R2: In a cycle where `en_i` is low and `order_sel_i` is unchanged, `offset_o` and all internal state hold their values.
- R3: With `order_sel_i` = 0 (first order), the j-th enabled output after a clear is floor(j·F/D) − floor((j−1)·F/D), so it is only ever 0 or +1.
- R4: The order is `order_sel_i` + 1. With order k, every output lies in [1 − 2^(k−1), 2^(k−1)]. For order 2 that is −1..+2, for order 3 it is −3..+4, and for order 4 it is −7..+8.
- R5: After n enabled outputs following a clear, the sum S of those outputs satisfies |D·S − n·F| ≤ 4·D for every order. The long-run mean of the output is therefore F/D.
- R6: A change of `order_sel_i` clears all accumulators and history on the next clock edge, and `offset_o` reads 0 after that edge. The sequence that follows is the one a fresh start would give.
- R7: With `frac_num_i` = 0 from a clear onward, every output is 0 at every order.
- R8: For D up to 4095 and F = D − 1, no accumulator wraps silently. Both the first-order sequence of R3 and the average bound of R5 still hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | One pulse per comparison cycle; advances the modulator |
| frac_num_i | input | 12 | Fractional numerator F, must be below D |
| frac_mod_i | input | 12 | Fractional modulus D, 1 to 4095 |
| order_sel_i | input | 2 | Order code, order = code + 1 |
| offset_o | output | 5 | Signed divide offset (two's complement) |

## Verification
The hardest case to reach from the ports is a restart in the middle of a sequence. The accumulators must be non-zero when `order_sel_i` changes, or an incomplete clear goes unseen. Each run therefore first leaves the order code at a neighbouring value and then returns it, with the accumulators primed by earlier runs. The first-order carry sequence, which is exact, then shows whether any residue survived. Large moduli with F = D − 1 drive the accumulators near their width limit, and the running-sum bound exposes any silent wrap there.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int MAX_ORDER = 4;
  localparam int ORD_W     = $clog2(MAX_ORDER);
  localparam int OUT_W     = MAX_ORDER + 1;

  typedef logic [ORD_W-1:0] order_code_t;

  // stage idx (0-based) takes part when idx < order
  function automatic logic stage_on(order_code_t code, int unsigned idx);
    return idx <= 32'(code);
  endfunction
endpackage

// File: rtl/dsm_acc_stage.sv
module dsm_acc_stage #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         act_i,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);
  localparam int SW = W + 1;

  logic [W-1:0]  acc_q;
  logic [SW-1:0] sum;
  logic          wrap;

  always_comb begin
    sum  = {1'b0, acc_q} + {1'b0, in_i};
    wrap = act_i && (sum >= {1'b0, mod_i});
    if (!act_i)    res_o = '0;
    else if (wrap) res_o = W'(sum - {1'b0, mod_i});
    else           res_o = sum[W-1:0];
  end

  assign carry_o = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (en_i)   acc_q <= res_o;
  end
endmodule

// File: rtl/dsm_noise_cancel.sv
module dsm_noise_cancel #(
  parameter int ORDER = 4,
  parameter int OW    = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic [ORDER-1:0]     carry_i,
  output logic signed [OW-1:0] y_o
);
  logic signed [OW-1:0] c_ext [ORDER];
  logic signed [OW-1:0] t     [ORDER];
  logic signed [OW-1:0] t_q   [1:ORDER-1];

  for (genvar i = 0; i < ORDER; i++) begin : g_ext
    assign c_ext[i] = {{(OW-1){1'b0}}, carry_i[i]};
  end

  assign t[ORDER-1] = c_ext[ORDER-1];

  // each level adds its carry to the first difference of the level below
  for (genvar i = 0; i < ORDER-1; i++) begin : g_diff
    assign t[i] = c_ext[i] + t[i+1] - t_q[i+1];
  end

  for (genvar i = 1; i < ORDER; i++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    t_q[i] <= '0;
      else if (clr_i) t_q[i] <= '0;
      else if (en_i)  t_q[i] <= t[i];
    end
  end

  assign y_o = t[0];
endmodule

// File: rtl/frac_dsm.sv
module frac_dsm #(
  parameter int FRAC_W = 12
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             en_i,
  input  logic [FRAC_W-1:0]                frac_num_i,
  input  logic [FRAC_W-1:0]                frac_mod_i,
  input  logic [dsm_pkg::ORD_W-1:0]        order_sel_i,
  output logic signed [dsm_pkg::OUT_W-1:0] offset_o
);
  import dsm_pkg::*;

  localparam int NST = MAX_ORDER;

  order_code_t          order_q;
  logic                 clr;
  logic [NST-1:0]       carry;
  logic [FRAC_W-1:0]    res [NST];
  logic signed [OUT_W-1:0] y_next, offset_q;

  assign clr = (order_sel_i != order_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) order_q <= '0;
    else         order_q <= order_sel_i;
  end

  for (genvar i = 0; i < NST; i++) begin : g_stage
    logic [FRAC_W-1:0] stage_in;
    if (i == 0) begin : g_head
      assign stage_in = frac_num_i;
    end else begin : g_tail
      assign stage_in = res[i-1];
    end

    dsm_acc_stage #(.W(FRAC_W)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr),
      .en_i    (en_i),
      .act_i   (stage_on(order_q, i)),
      .in_i    (stage_in),
      .mod_i   (frac_mod_i),
      .res_o   (res[i]),
      .carry_o (carry[i])
    );
  end

  dsm_noise_cancel #(.ORDER(NST), .OW(OUT_W)) u_cancel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .en_i    (en_i),
    .carry_i (carry),
    .y_o     (y_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    offset_q <= '0;
    else if (clr)   offset_q <= '0;
    else if (en_i)  offset_q <= y_next;
  end

  assign offset_o = offset_q;
endmodule

// File: rtl/frac_dsm_chk.sv
module frac_dsm_chk (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             en_i,
  input logic [dsm_pkg::ORD_W-1:0]        order_sel_i,
  input logic [dsm_pkg::ORD_W-1:0]        order_q,
  input logic signed [dsm_pkg::OUT_W-1:0] offset_o
);
  int v, hi, lo;
  always_comb begin
    v  = int'(offset_o);
    hi = 1 << order_q;
    lo = 1 - hi;
  end

  // R2: idle cycles leave the output alone
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && order_sel_i == order_q) |=> $stable(offset_o));

  // R3: first order emits only 0 or +1
  a_r3_binary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (order_q == '0) |-> (v == 0 || v == 1));

  // R4: output within the span of the active order
  a_r4_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v >= lo) && (v <= hi));

  // R6: order change clears the output and adopts the new code
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (order_sel_i != order_q) |=> (offset_o == '0) && (order_q == $past(order_sel_i)));
endmodule

bind frac_dsm frac_dsm_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .order_sel_i (order_sel_i),
  .order_q     (order_q),
  .offset_o    (offset_o)
);

// File: tb/frac_dsm_bench.sv
`timescale 1ns/1ps
module frac_dsm_bench;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              en;
  logic [11:0]       num, dmod;
  logic [1:0]        ord;
  logic signed [4:0] offset;

  typedef struct {
    int    lo;
    int    hi;
    string req;
  } item_t;

  item_t exp_q[$];
  int    n_chk = 0, n_fail = 0;
  int    sum_y = 0, n_mon = 0;
  bit    done = 1'b0;

  always #4 clk = ~clk;

  frac_dsm u_frac_dsm (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .frac_num_i  (num),
    .frac_mod_i  (dmod),
    .order_sel_i (ord),
    .offset_o    (offset)
  );

  task automatic chk(input bit ok, input string req, input int act, input string expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%s", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: pops one expected item per enabled edge
  initial begin
    forever begin
      bit fired;
      @(posedge clk);
      fired = en && rst_n;
      @(negedge clk);
      if (fired) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "scoreboard-empty", int'(offset), "item");
        end else begin
          item_t it;
          int    v;
          it = exp_q.pop_front();
          v  = int'(offset);
          sum_y += v;
          n_mon++;
          chk(v >= it.lo && v <= it.hi, it.req, v, $sformatf("%0d..%0d", it.lo, it.hi));
        end
      end
    end
  end

  // driver: restart via order toggle, then n enabled samples
  task automatic run(input int code, input int f, input int d, input int n, input string tag);
    int    hold_v;
    longint err;
    @(negedge clk);
    ord  = 2'(code ^ 1);
    num  = 12'(f);
    dmod = 12'(d);
    @(negedge clk);
    ord = 2'(code);
    @(negedge clk);
    chk(offset == 0, "R6", int'(offset), "0");
    sum_y = 0;
    n_mon = 0;
    for (int j = 1; j <= n; j++) begin
      item_t it;
      if (f == 0) begin
        it.lo = 0; it.hi = 0; it.req = "R7";
      end else if (code == 0) begin
        it.lo = (j * f) / d - ((j - 1) * f) / d;
        it.hi = it.lo;
        it.req = {"R3/", tag};
      end else begin
        it.lo = 1 - (1 << code);
        it.hi = 1 << code;
        it.req = {"R4/", tag};
      end
      exp_q.push_back(it);
      en = 1'b1;
      @(negedge clk);
    end
    en = 1'b0;
    @(negedge clk);
    #1;
    chk(n_mon == n, "scoreboard-count", n_mon, $sformatf("%0d", n));
    err = longint'(d) * sum_y - longint'(n) * f;
    chk(err <= 4 * d && err >= -4 * d, {"R5/", tag}, int'(err), $sformatf("within +-%0d", 4 * d));
    hold_v = int'(offset);
    repeat (3) @(negedge clk);
    chk(int'(offset) == hold_v, "R2", int'(offset), $sformatf("%0d", hold_v));
  endtask

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    num   = '0;
    dmod  = 12'd5;
    ord   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(offset == 0, "R1", int'(offset), "0");

    run(0, 1, 5, 40, "R3");
    run(0, 4094, 4095, 150, "R8");
    run(1, 1, 5, 60, "R4");
    run(1, 2047, 4095, 200, "R4");
    run(2, 3, 7, 150, "R4");
    run(3, 7, 1968, 300, "R4");
    run(3, 4094, 4095, 300, "R8");
    run(2, 5, 11, 37, "R4");
    run(0, 3, 7, 30, "R6");
    run(3, 0, 13, 30, "R7");
    run(0, 0, 9, 10, "R7");
    run(1, 4094, 4095, 120, "R8");

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule